// File: doc/BRIEF.md
# One-Way Security and Identification Register Bank

This block holds the special setting registers that sit beside a microcontroller's on-chip program memory while that memory is being programmed. It keeps one security byte whose bits can only be cleared by programming and only set again by a whole-array erase. It also returns two fixed identification bytes. All of these registers are reachable only while the chip is held in its programming-mode pin condition. That condition is: chip reset high, address latch enable low and program store enable high.

The security byte drives four decoded controls for the rest of the chip: a lock, a code-read inhibit, an encryption enable and an oscillator gain select. A gating path uses the code-read inhibit to replace internal code with all ones when a table read started from external code tries to fetch it. The security value models non-volatile storage. It is cleared to all ones only by the power-on input or by an erase, and toggling the chip reset pin does not change it.

Top module: `secreg_bank`

## Requirements
- R1: Access needs the programming-mode condition chip_rst=1, addr_latch_en=0, prog_store_en=1. Outside that condition a read strobe loads rdata with 8'h00, and program and erase strobes change nothing.
- R2: In programming mode, address 16'hFFFF selects the security byte for reads and programs.
- R3: A program of the security byte stores old AND wdata, so bits only go 1 to 0. A bit already at 0 stays 0 whatever is written.
- R4: An accepted erase strobe sets the security byte to 8'hFF at the next clock edge. erase_done is high for exactly the one cycle after that edge.
- R5: Reserved bits 6 to 3 of the security byte always hold 1 and cannot be cleared.
- R6: In programming mode, any address other than 16'hFFFF reads an identification byte. addr[0]=0 returns 8'hDA and addr[0]=1 returns 8'hE0. A program to those addresses changes nothing.
- R7: When program and erase strobes are accepted in the same cycle, the erase wins and the result is 8'hFF.
- R8: The decoded controls follow the stored security byte. lock_on is the inverse of bit 0, code_read_block is the inverse of bit 1, crypt_en is the inverse of bit 2, and osc_full_gain equals bit 7 (1 means full gain, 0 means half gain).
- R9: When tbl_from_ext=1 and code_read_block=1, tbl_code_out is 8'hFF. Otherwise it equals tbl_code_in.
- R10: rdata is registered: it shows the selected value one clock after the read strobe and holds between strobes. A read in the cycle right after a program or erase returns the updated byte.
- R11: The security byte survives changes of chip_rst. Only por_n low (power-on) or an erase returns it to 8'hFF, and por_n also clears rdata and erase_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on clear, active low |
| chip_rst | input | 1 | Chip reset pin level, must be 1 for access |
| addr_latch_en | input | 1 | Address latch enable pin, must be 0 for access |
| prog_store_en | input | 1 | Program store enable pin, must be 1 for access |
| addr | input | 16 | Register address |
| wdata | input | 8 | Program data |
| prog_stb | input | 1 | Program strobe |
| erase_stb | input | 1 | Erase-all strobe |
| rd_stb | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |
| erase_done | output | 1 | One-cycle pulse after an accepted erase |
| lock_on | output | 1 | Lock active |
| code_read_block | output | 1 | Internal code blocked from external table reads |
| crypt_en | output | 1 | Encryption enabled |
| osc_full_gain | output | 1 | Oscillator at full gain |
| tbl_from_ext | input | 1 | Current table read was started by external code |
| tbl_code_in | input | 8 | Internal code byte for the table read |
| tbl_code_out | output | 8 | Gated code byte |

## Verification
The bench builds the block with its default parameters. These are a 16-bit address, 8-bit data, the security byte at the top address, identification bytes 8'hDA and 8'hE0, and reserved mask 8'h78. With these values both sides of the address decode are in reach: the top address and low addresses whose bit 0 picks the identification byte. Clearing patterns reach every security bit, including the reserved ones. Together they show the one-way behaviour and every decoded control in both states.

// File: rtl/secreg_pkg.sv
package secreg_pkg;
    typedef enum logic [1:0] {
        SRC_NONE    = 2'd0,
        SRC_SEC     = 2'd1,
        SRC_COMPANY = 2'd2,
        SRC_DEVICE  = 2'd3
    } rd_src_e;
endpackage

// File: rtl/secreg_mode_dec.sv
module secreg_mode_dec
    import secreg_pkg::*;
#(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] SEC_ADDR = '1
) (
    input  logic              chip_rst,
    input  logic              addr_latch_en,
    input  logic              prog_store_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              prog_stb,
    input  logic              erase_stb,
    input  logic              rd_stb,
    output logic              do_prog,
    output logic              do_erase,
    output logic              do_read,
    output rd_src_e           rd_src
);
    logic in_mode;
    logic hit_sec;

    always_comb begin
        in_mode  = chip_rst && !addr_latch_en && prog_store_en;
        hit_sec  = (addr == SEC_ADDR);
        do_erase = in_mode && erase_stb;
        do_prog  = in_mode && prog_stb && hit_sec && !erase_stb;
        do_read  = rd_stb;
        if (!in_mode)
            rd_src = SRC_NONE;
        else if (hit_sec)
            rd_src = SRC_SEC;
        else if (addr[0])
            rd_src = SRC_DEVICE;
        else
            rd_src = SRC_COMPANY;
    end
endmodule

// File: rtl/secreg_store.sv
module secreg_store #(
    parameter int               DATA_W    = 8,
    parameter logic [DATA_W-1:0] RSVD_MASK = 8'h78
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              do_prog,
    input  logic              do_erase,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] sec_q,
    output logic              erased_q
);
    typedef struct packed {
        logic [DATA_W-1:0] sec;
        logic              erased;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.erased = 1'b0;
        if (do_erase) begin
            st_d.sec    = '1;
            st_d.erased = 1'b1;
        end else if (do_prog) begin
            st_d.sec = st_q.sec & (wdata | RSVD_MASK);
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q.sec    <= '1;
            st_q.erased <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sec_q    = st_q.sec;
    assign erased_q = st_q.erased;
endmodule

// File: rtl/secreg_rdport.sv
module secreg_rdport
    import secreg_pkg::*;
#(
    parameter int               DATA_W     = 8,
    parameter logic [DATA_W-1:0] COMPANY_ID = 8'hDA,
    parameter logic [DATA_W-1:0] DEVICE_ID  = 8'hE0
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              do_read,
    input  rd_src_e           rd_src,
    input  logic [DATA_W-1:0] sec,
    output logic [DATA_W-1:0] rdata
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
    } rd_t;

    rd_t rd_d, rd_q;

    always_comb begin
        rd_d = rd_q;
        if (do_read) begin
            unique case (rd_src)
                SRC_SEC:     rd_d.data = sec;
                SRC_COMPANY: rd_d.data = COMPANY_ID;
                SRC_DEVICE:  rd_d.data = DEVICE_ID;
                default:     rd_d.data = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) rd_q.data <= '0;
        else        rd_q      <= rd_d;
    end

    assign rdata = rd_q.data;
endmodule

// File: rtl/secreg_codegate.sv
module secreg_codegate #(
    parameter int DATA_W = 8
) (
    input  logic              block,
    input  logic              from_ext,
    input  logic [DATA_W-1:0] code_in,
    output logic [DATA_W-1:0] code_out
);
    always_comb begin
        code_out = (block && from_ext) ? '1 : code_in;
    end
endmodule

// File: rtl/secreg_bank.sv
module secreg_bank
    import secreg_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 8,
    parameter logic [ADDR_W-1:0] SEC_ADDR   = '1,
    parameter logic [DATA_W-1:0] COMPANY_ID = 8'hDA,
    parameter logic [DATA_W-1:0] DEVICE_ID  = 8'hE0,
    parameter logic [DATA_W-1:0] RSVD_MASK  = 8'h78,
    parameter int LOCK_BIT   = 0,
    parameter int INHIB_BIT  = 1,
    parameter int CRYPT_BIT  = 2,
    parameter int GAIN_BIT   = 7
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              chip_rst,
    input  logic              addr_latch_en,
    input  logic              prog_store_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              prog_stb,
    input  logic              erase_stb,
    input  logic              rd_stb,
    output logic [DATA_W-1:0] rdata,
    output logic              erase_done,
    output logic              lock_on,
    output logic              code_read_block,
    output logic              crypt_en,
    output logic              osc_full_gain,
    input  logic              tbl_from_ext,
    input  logic [DATA_W-1:0] tbl_code_in,
    output logic [DATA_W-1:0] tbl_code_out
);
    logic              do_prog, do_erase, do_read;
    rd_src_e           rd_src;
    logic [DATA_W-1:0] sec_q;

    secreg_mode_dec #(.ADDR_W(ADDR_W), .SEC_ADDR(SEC_ADDR)) u_dec (
        .chip_rst      (chip_rst),
        .addr_latch_en (addr_latch_en),
        .prog_store_en (prog_store_en),
        .addr          (addr),
        .prog_stb      (prog_stb),
        .erase_stb     (erase_stb),
        .rd_stb        (rd_stb),
        .do_prog       (do_prog),
        .do_erase      (do_erase),
        .do_read       (do_read),
        .rd_src        (rd_src)
    );

    secreg_store #(.DATA_W(DATA_W), .RSVD_MASK(RSVD_MASK)) u_store (
        .clk      (clk),
        .por_n    (por_n),
        .do_prog  (do_prog),
        .do_erase (do_erase),
        .wdata    (wdata),
        .sec_q    (sec_q),
        .erased_q (erase_done)
    );

    secreg_rdport #(.DATA_W(DATA_W), .COMPANY_ID(COMPANY_ID), .DEVICE_ID(DEVICE_ID)) u_rd (
        .clk     (clk),
        .por_n   (por_n),
        .do_read (do_read),
        .rd_src  (rd_src),
        .sec     (sec_q),
        .rdata   (rdata)
    );

    always_comb begin
        lock_on         = !sec_q[LOCK_BIT];
        code_read_block = !sec_q[INHIB_BIT];
        crypt_en        = !sec_q[CRYPT_BIT];
        osc_full_gain   = sec_q[GAIN_BIT];
    end

    secreg_codegate #(.DATA_W(DATA_W)) u_gate (
        .block    (code_read_block),
        .from_ext (tbl_from_ext),
        .code_in  (tbl_code_in),
        .code_out (tbl_code_out)
    );
endmodule

// File: rtl/secreg_bank_chk.sv
module secreg_bank_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] SEC_ADDR  = '1,
    parameter logic [DATA_W-1:0] RSVD_MASK = 8'h78
) (
    input logic              clk,
    input logic              por_n,
    input logic              chip_rst,
    input logic              addr_latch_en,
    input logic              prog_store_en,
    input logic [ADDR_W-1:0] addr,
    input logic              prog_stb,
    input logic              erase_stb,
    input logic              rd_stb,
    input logic [DATA_W-1:0] sec_q,
    input logic [DATA_W-1:0] rdata,
    input logic              erase_done,
    input logic              code_read_block,
    input logic              tbl_from_ext,
    input logic [DATA_W-1:0] tbl_code_out
);
    logic mode;
    assign mode = chip_rst && !addr_latch_en && prog_store_en;

    // R1: nothing changes the security byte outside programming mode
    a_r1_no_access_outside: assert property (@(posedge clk) disable iff (!por_n)
        !mode |=> $stable(sec_q));

    // R3: program never raises a bit
    a_r3_one_way: assert property (@(posedge clk) disable iff (!por_n)
        (mode && prog_stb && !erase_stb) |=> ((sec_q & ~$past(sec_q)) == '0));

    // R4 and R7: erase restores all ones and pulses erase_done
    a_r4_erase_sets: assert property (@(posedge clk) disable iff (!por_n)
        (mode && erase_stb) |=> (sec_q == '1 && erase_done));

    // R4: erase_done only follows an accepted erase
    a_r4_done_cause: assert property (@(posedge clk) disable iff (!por_n)
        erase_done |-> $past(mode && erase_stb));

    // R5: reserved bits stay 1
    a_r5_rsvd_set: assert property (@(posedge clk) disable iff (!por_n)
        (sec_q & RSVD_MASK) == RSVD_MASK);

    // R6: programs to non-security addresses change nothing
    a_r6_id_readonly: assert property (@(posedge clk) disable iff (!por_n)
        (prog_stb && !erase_stb && addr != SEC_ADDR) |=> $stable(sec_q));

    // R9: blocked table reads return all ones
    a_r9_gate: assert property (@(posedge clk) disable iff (!por_n)
        (tbl_from_ext && code_read_block) |-> tbl_code_out == '1);

    // R10: rdata holds between read strobes
    a_r10_hold: assert property (@(posedge clk) disable iff (!por_n)
        !rd_stb |=> $stable(rdata));
endmodule

bind secreg_bank secreg_bank_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEC_ADDR(SEC_ADDR), .RSVD_MASK(RSVD_MASK)
) u_chk (
    .clk             (clk),
    .por_n           (por_n),
    .chip_rst        (chip_rst),
    .addr_latch_en   (addr_latch_en),
    .prog_store_en   (prog_store_en),
    .addr            (addr),
    .prog_stb        (prog_stb),
    .erase_stb       (erase_stb),
    .rd_stb          (rd_stb),
    .sec_q           (sec_q),
    .rdata           (rdata),
    .erase_done      (erase_done),
    .code_read_block (code_read_block),
    .tbl_from_ext    (tbl_from_ext),
    .tbl_code_out    (tbl_code_out)
);

// File: tb/secreg_bank_tb.sv
module secreg_bank_tb;
    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        chip_rst = 1'b1, addr_latch_en = 1'b0, prog_store_en = 1'b1;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        prog_stb = 0, erase_stb = 0, rd_stb = 0;
    logic [7:0]  rdata;
    logic        erase_done, lock_on, code_read_block, crypt_en, osc_full_gain;
    logic        tbl_from_ext = 0;
    logic [7:0]  tbl_code_in = '0;
    logic [7:0]  tbl_code_out;

    int errors = 0, checks = 0;
    bit finished = 0;
    logic [7:0] sec_m = 8'hFF;
    localparam logic [7:0] RSVD = 8'h78;

    always #5 clk = ~clk;

    secreg_bank u_dut (
        .clk(clk), .por_n(por_n), .chip_rst(chip_rst), .addr_latch_en(addr_latch_en),
        .prog_store_en(prog_store_en), .addr(addr), .wdata(wdata), .prog_stb(prog_stb),
        .erase_stb(erase_stb), .rd_stb(rd_stb), .rdata(rdata), .erase_done(erase_done),
        .lock_on(lock_on), .code_read_block(code_read_block), .crypt_en(crypt_en),
        .osc_full_gain(osc_full_gain), .tbl_from_ext(tbl_from_ext),
        .tbl_code_in(tbl_code_in), .tbl_code_out(tbl_code_out)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [15:0] a);
        @(negedge clk); addr = a; rd_stb = 1;
        @(negedge clk); rd_stb = 0;
    endtask

    task automatic prog(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; prog_stb = 1;
        @(negedge clk); prog_stb = 0;
    endtask

    task automatic check_ctrl(input string req);
        chk(req, {4'b0, lock_on, code_read_block, crypt_en, osc_full_gain},
            {4'b0, !sec_m[0], !sec_m[1], !sec_m[2], sec_m[7]});
    endtask

    task automatic t_reset;
        chk("R11 rdata after por", rdata, 8'h00);
        chk("R11 erase_done after por", {7'b0, erase_done}, 8'h00);
        check_ctrl("R8 controls after por");
    endtask

    task automatic t_read_ids;
        rd(16'hFFFF); chk("R2 read security", rdata, sec_m);
        rd(16'h0000); chk("R6 company id", rdata, 8'hDA);
        rd(16'h0001); chk("R6 device id", rdata, 8'hE0);
        rd(16'h1234); chk("R6 id by addr0", rdata, 8'hDA);
    endtask

    task automatic t_program;
        prog(16'hFFFF, 8'hFE); sec_m &= (8'hFE | RSVD);
        rd(16'hFFFF); chk("R10 verify after program", rdata, sec_m);
        check_ctrl("R8 lock after program");
        prog(16'hFFFF, 8'hFF);
        rd(16'hFFFF); chk("R3 no set back to 1", rdata, sec_m);
        prog(16'hFFFF, 8'h01); sec_m &= (8'h01 | RSVD);
        rd(16'hFFFF); chk("R3 clear by and", rdata, 8'h78);
        chk("R5 reserved stay 1", rdata & RSVD, RSVD);
        check_ctrl("R8 all controls cleared state");
        prog(16'h0000, 8'h00);
        rd(16'hFFFF); chk("R6 program to id ignored", rdata, sec_m);
        rd(16'h0000); chk("R6 company id unchanged", rdata, 8'hDA);
    endtask

    task automatic t_hold;
        rd(16'h0001);
        @(negedge clk); addr = 16'hFFFF;
        @(negedge clk); chk("R10 rdata holds without strobe", rdata, 8'hE0);
    endtask

    task automatic t_gate;
        @(negedge clk); tbl_from_ext = 1; tbl_code_in = 8'h5A;
        #1 chk("R9 blocked table read", tbl_code_out, 8'hFF);
        tbl_from_ext = 0;
        #1 chk("R9 internal access passes", tbl_code_out, 8'h5A);
    endtask

    task automatic t_outside;
        @(negedge clk); addr_latch_en = 1;
        rd(16'hFFFF); chk("R1 read outside mode", rdata, 8'h00);
        @(negedge clk); erase_stb = 1;
        @(negedge clk); erase_stb = 0;
        chk("R1 erase outside no pulse", {7'b0, erase_done}, 8'h00);
        @(negedge clk); addr_latch_en = 0; prog_store_en = 0;
        prog(16'hFFFF, 8'h00);
        @(negedge clk); prog_store_en = 1;
        rd(16'hFFFF); chk("R1 state unchanged outside mode", rdata, sec_m);
    endtask

    task automatic t_chip_rst;
        @(negedge clk); chip_rst = 0;
        repeat (3) @(negedge clk);
        chip_rst = 1;
        rd(16'hFFFF); chk("R11 survives chip_rst", rdata, sec_m);
    endtask

    task automatic t_erase;
        @(negedge clk); erase_stb = 1;
        @(negedge clk); erase_stb = 0; sec_m = 8'hFF;
        chk("R4 erase_done pulse", {7'b0, erase_done}, 8'h01);
        @(negedge clk);
        chk("R4 erase_done one cycle", {7'b0, erase_done}, 8'h00);
        rd(16'hFFFF); chk("R4 erase restores ones", rdata, 8'hFF);
        check_ctrl("R8 controls after erase");
        @(negedge clk); tbl_from_ext = 1; tbl_code_in = 8'h33;
        #1 chk("R9 unblocked after erase", tbl_code_out, 8'h33);
        tbl_from_ext = 0;
    endtask

    task automatic t_priority;
        @(negedge clk); addr = 16'hFFFF; wdata = 8'h00; prog_stb = 1; erase_stb = 1;
        @(negedge clk); prog_stb = 0; erase_stb = 0;
        rd(16'hFFFF); chk("R7 erase beats program", rdata, 8'hFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        por_n = 1;
        @(negedge clk);
        t_reset();
        t_read_ids();
        t_program();
        t_hold();
        t_gate();
        t_outside();
        t_chip_rst();
        t_erase();
        t_priority();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule